// File: doc/BRIEF.md
# Field Envelope Command Receiver

This block sits beside the readout sequencer of a passive transponder and listens for a reader that wants to talk. While the tag is reading out, the block samples one peak-detector result per bit period. When it sees a run of high-field samples followed by a low one, it takes over the modulator load and holds it on. It then watches the field at eight samples per bit period for a high-field sample followed by a start bit.

Once a start bit qualifies, the block receives NRZ bits with the first bit in the most significant position. During reception it keeps switching the load off for the first half of each bit slot and on for the second half, so the tag goes on harvesting energy, and it samples the field at the end of each on half. A single byte is decoded as a command. The reset, read-ID and read-configuration commands change the readout mode. The two write commands continue for three more framed bytes, which are handed on unchanged.

Top module: `envCmdRx`

## Requirements
- R1: After reset, mode is 0 (user readout), loadOn and rxBusy are 0, and cmdValid and byteValid are 0.
- R2: When at least 4 consecutive bitStrobe samples are high and a later bitStrobe sample is low, the receiver takes the load: rxBusy=1 and loadOn=1 until a start bit is found or the envelope watchdog expires.
- R3: After the envelope, the field is sampled every eighth of a bit period. Reception starts on three consecutive low samples that follow a high sample. If no start bit arrives within 8 bit periods, rxBusy returns to 0.
- R4: During reception each bit slot has loadOn=0 for exactly half a bit period, then loadOn=1 for the second half. The bit is sampled at the end of the on half, which falls 3/8 to 1/2 of a bit period into each transmitted bit.
- R5: A high field is received as 1 and a low field as 0. The first received bit is byteData[7]. byteValid pulses for one cycle per received byte.
- R6: The first byte of a frame raises cmdValid together with byteValid, with cmdKind encoding it as follows: 0xA0 gives 1 (reset), 0xA5 gives 2 (read ID), 0xF0 gives 3 (read configuration), any 0xCx gives 4 (word write), 0xD3 gives 5 (configuration write), and any other value gives 6.
- R7: cmdKind 1 sets mode to 0 from any mode. cmdKind 2 sets mode to 1 and cmdKind 3 sets mode to 2, but only when mode is 0. Every other command leaves mode unchanged.
- R8: After a write command byte, the block receives 3 more bytes, each framed by a low start bit and a high stop bit. byteIdx is 0 to 3 in arrival order. Between bytes the load is off for half a bit period, then on while the block waits for the next start bit.
- R9: If no start bit arrives within 2 bit periods between write bytes, rxBusy returns to 0 and envelope detection is available again at once.
- R10: Envelope detection is disabled for 128 bitStrobe periods after reset, after a reset command, and after an envelope watchdog timeout. An envelope sent in that window produces no byte and no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock, one cycle per field period |
| rstN | input | 1 | Active-low reset (power-on) |
| bitStrobe | input | 1 | One-cycle pulse per readout bit period |
| fieldHigh | input | 1 | Peak-detector result: 1 = high field, 0 = low field |
| cmdValid | output | 1 | One-cycle pulse when a command byte is decoded |
| cmdKind | output | 3 | Decoded command class (see R6) |
| byteValid | output | 1 | One-cycle pulse per received byte |
| byteData | output | 8 | Received byte, first bit in bit 7 |
| byteIdx | output | 2 | Position of the byte within its frame |
| mode | output | 2 | Readout mode: 0 user, 1 ID, 2 configuration |
| loadOn | output | 1 | Modulator load request while rxBusy is 1 |
| rxBusy | output | 1 | Receiver owns the modulator load |

## Verification
The assertions assume that fieldHigh is a clean level in the carrier clock domain, and that bitStrobe arrives as isolated one-cycle pulses at a fixed bit period. The stimulus keeps to this. It changes the field only on falling clock edges and produces bitStrobe from a free-running divider. Every reader bit lasts exactly one bit period, so each eighth-rate sample and each slot-end sample falls well inside a stable field level. The phase-two and phase-three times are 3 bit periods each, so a correct frame always finds its start bit inside both watchdog windows.

// File: rtl/envrx_pkg.sv
package envrx_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_ID   = 2'd1,
    MODE_CFG  = 2'd2
  } rdMode_t;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_RST    = 3'd1,
    K_RDID   = 3'd2,
    K_RDCFG  = 3'd3,
    K_WRWORD = 3'd4,
    K_WRCFG  = 3'd5,
    K_OTHER  = 3'd6
  } cmdKind_t;

  typedef enum logic [2:0] {
    S_LISTEN = 3'd0,
    S_ARMED  = 3'd1,
    S_HUNT   = 3'd2,
    S_RX     = 3'd3,
    S_STOP   = 3'd4,
    S_GAP    = 3'd5
  } rxState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic huntClr;
    logic huntEn;
    logic longWait;
    logic rxStart;
    logic rxRun;
    logic listenEn;
    logic blockLoad;
  } rxCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic       highsMet;
    logic       blocked;
    logic       startFound;
    logic       waitExpired;
    logic       byteFull;
    logic       halfDone;
    logic       rxLoad;
    logic [7:0] rxByte;
  } rxSts_t;

  function automatic cmdKind_t classify(input logic [7:0] b);
    if (b == 8'hA0)           return K_RST;
    else if (b == 8'hA5)      return K_RDID;
    else if (b == 8'hF0)      return K_RDCFG;
    else if (b[7:4] == 4'hC)  return K_WRWORD;
    else if (b == 8'hD3)      return K_WRCFG;
    else                      return K_OTHER;
  endfunction

endpackage

// File: rtl/envRxDatapath.sv
module envRxDatapath
  import envrx_pkg::*;
#(
  parameter int BIT_CLKS       = 64,
  parameter int SYNC_HIGHS     = 4,
  parameter int SYNC_WAIT_BITS = 8,
  parameter int GAP_WAIT_BITS  = 2,
  parameter int BLOCK_BITS     = 128
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitStrobe,
  input  logic   fieldHigh,
  input  rxCtl_t ctl,
  output rxSts_t sts
);

  localparam int EIGHTH      = BIT_CLKS / 8;
  localparam int EW          = $clog2(EIGHTH);
  localparam int PW          = $clog2(BIT_CLKS);
  localparam int LONG_TICKS  = SYNC_WAIT_BITS * 8;
  localparam int SHORT_TICKS = GAP_WAIT_BITS * 8;
  localparam int WW          = $clog2(LONG_TICKS);
  localparam int HW          = $clog2(SYNC_HIGHS + 1);
  localparam int KW          = $clog2(BLOCK_BITS + 1);

  localparam logic [EW-1:0] E_LAST       = EW'(EIGHTH - 1);
  localparam logic [PW-1:0] PH_LAST      = PW'(BIT_CLKS - 1);
  localparam logic [PW-1:0] PH_START     = PW'(BIT_CLKS - EIGHTH);
  localparam logic [PW-1:0] PH_HALF      = PW'(BIT_CLKS / 2);
  localparam logic [PW-1:0] PH_HALF_LAST = PW'(BIT_CLKS / 2 - 1);
  localparam logic [WW-1:0] LONG_LAST    = WW'(LONG_TICKS - 1);
  localparam logic [WW-1:0] SHORT_LAST   = WW'(SHORT_TICKS - 1);
  localparam logic [HW-1:0] HIGH_GOAL    = HW'(SYNC_HIGHS);
  localparam logic [KW-1:0] BLOCK_INIT   = KW'(BLOCK_BITS);

  // ---------------- envelope listener and block window ----------------
  logic [HW-1:0] highCnt;
  logic [KW-1:0] blockCnt;
  logic          blocked;

  assign blocked = (blockCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockCnt <= BLOCK_INIT;
      highCnt  <= '0;
    end else begin
      if (ctl.blockLoad)
        blockCnt <= BLOCK_INIT;
      else if (bitStrobe && blocked)
        blockCnt <= blockCnt - 1'b1;

      if (!ctl.listenEn || blocked)
        highCnt <= '0;
      else if (bitStrobe) begin
        if (!fieldHigh)
          highCnt <= '0;
        else if (highCnt != HIGH_GOAL)
          highCnt <= highCnt + 1'b1;
      end
    end
  end

  // ---------------- eighth-rate start-bit hunter ----------------
  logic [EW-1:0] eCnt;
  logic [WW-1:0] wCnt;
  logic [1:0]    lowRun;
  logic          sawHigh;
  logic          eighthTick;
  logic [WW-1:0] wLimit;

  assign eighthTick = ctl.huntEn && (eCnt == E_LAST);
  assign wLimit     = ctl.longWait ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eCnt    <= '0;
      wCnt    <= '0;
      lowRun  <= '0;
      sawHigh <= 1'b0;
    end else if (ctl.huntClr) begin
      eCnt    <= '0;
      wCnt    <= '0;
      lowRun  <= '0;
      sawHigh <= 1'b0;
    end else if (ctl.huntEn) begin
      eCnt <= eighthTick ? '0 : eCnt + 1'b1;
      if (eighthTick) begin
        if (wCnt != wLimit) wCnt <= wCnt + 1'b1;
        if (fieldHigh) begin
          sawHigh <= 1'b1;
          lowRun  <= '0;
        end else if (sawHigh && lowRun != 2'd3) begin
          lowRun <= lowRun + 1'b1;
        end
      end
    end
  end

  // ---------------- bit-slot receiver ----------------
  logic [PW-1:0] rxPh;
  logic          lead;
  logic [3:0]    sampCnt;
  logic [7:0]    shiftReg;
  logic          slotEnd;

  assign slotEnd = ctl.rxRun && (rxPh == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPh     <= '0;
      lead     <= 1'b0;
      sampCnt  <= '0;
      shiftReg <= '0;
    end else if (ctl.rxStart) begin
      rxPh     <= PH_START;
      lead     <= 1'b1;
      sampCnt  <= '0;
      shiftReg <= '0;
    end else if (ctl.rxRun) begin
      rxPh <= slotEnd ? '0 : rxPh + 1'b1;
      if (slotEnd) begin
        if (lead)
          lead <= 1'b0;
        else if (sampCnt != 4'd8) begin
          shiftReg <= {shiftReg[6:0], fieldHigh};
          sampCnt  <= sampCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    sts.highsMet    = (highCnt == HIGH_GOAL);
    sts.blocked     = blocked;
    sts.startFound  = eighthTick && !fieldHigh && sawHigh && (lowRun == 2'd2);
    sts.waitExpired = eighthTick && (wCnt == wLimit);
    sts.byteFull    = (sampCnt == 4'd8);
    sts.halfDone    = ctl.rxRun && (rxPh == PH_HALF_LAST);
    sts.rxLoad      = lead || (rxPh >= PH_HALF);
    sts.rxByte      = shiftReg;
  end

  // R4: no more than eight samples per byte
  a_r4_sample_cap: assert property (@(posedge clk) disable iff (!rstN)
    sampCnt <= 4'd8);

  // R4: the lead-in slot ends before any bit is taken
  a_r4_lead_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lead) |-> sampCnt == 4'd0);

  // R10: the block window never exceeds its length
  a_r10_block_len: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && blocked && !ctl.blockLoad) |=> blockCnt < BLOCK_INIT);

endmodule

// File: rtl/envRxControl.sv
module envRxControl
  import envrx_pkg::*;
#(
  parameter int WRITE_BYTES = 4,
  parameter int IW          = $clog2(WRITE_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitStrobe,
  input  logic          fieldHigh,
  input  rxSts_t        sts,
  output rxCtl_t        ctl,
  output logic          cmdValid,
  output cmdKind_t      cmdKind,
  output logic          byteValid,
  output logic [7:0]    byteData,
  output logic [IW-1:0] byteIdx,
  output rdMode_t       mode,
  output logic          loadOn,
  output logic          rxBusy
);

  localparam logic [IW-1:0] LAST_IDX = IW'(WRITE_BYTES - 1);

  rxState_t      state;
  logic [IW-1:0] byteNo;
  logic          rxDone;
  cmdKind_t      kindNow;

  assign rxDone  = (state == S_RX) && sts.byteFull;
  assign kindNow = classify(sts.rxByte);

  always_comb begin
    ctl.listenEn  = (state == S_LISTEN);
    ctl.huntEn    = (state == S_HUNT) || (state == S_GAP);
    ctl.longWait  = (state == S_HUNT);
    ctl.rxRun     = (state == S_RX) || (state == S_STOP);
    ctl.huntClr   = ((state == S_ARMED) && bitStrobe && !fieldHigh) ||
                    ((state == S_STOP) && sts.halfDone);
    ctl.rxStart   = ctl.huntEn && sts.startFound;
    ctl.blockLoad = ((state == S_HUNT) && sts.waitExpired && !sts.startFound) ||
                    (rxDone && (byteNo == '0) && (kindNow == K_RST));
  end

  always_comb begin
    case (state)
      S_HUNT, S_GAP: loadOn = 1'b1;
      S_RX:          loadOn = sts.rxLoad;
      default:       loadOn = 1'b0;
    endcase
    rxBusy = (state == S_HUNT) || (state == S_RX) ||
             (state == S_STOP) || (state == S_GAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_LISTEN;
      byteNo    <= '0;
      mode      <= MODE_READ;
      cmdValid  <= 1'b0;
      cmdKind   <= K_NONE;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteIdx   <= '0;
    end else begin
      cmdValid  <= 1'b0;
      byteValid <= 1'b0;
      case (state)
        S_LISTEN: if (sts.highsMet) state <= S_ARMED;
        S_ARMED:  if (bitStrobe && !fieldHigh) state <= S_HUNT;
        S_HUNT: begin
          if (sts.startFound) begin
            state  <= S_RX;
            byteNo <= '0;
          end else if (sts.waitExpired) begin
            state <= S_LISTEN;
          end
        end
        S_RX: begin
          if (sts.byteFull) begin
            byteValid <= 1'b1;
            byteData  <= sts.rxByte;
            byteIdx   <= byteNo;
            if (byteNo == '0) begin
              cmdValid <= 1'b1;
              cmdKind  <= kindNow;
              case (kindNow)
                K_RST:   mode <= MODE_READ;
                K_RDID:  if (mode == MODE_READ) mode <= MODE_ID;
                K_RDCFG: if (mode == MODE_READ) mode <= MODE_CFG;
                default: ;
              endcase
              if (kindNow == K_WRWORD || kindNow == K_WRCFG) begin
                byteNo <= byteNo + 1'b1;
                state  <= S_STOP;
              end else begin
                state <= S_LISTEN;
              end
            end else if (byteNo == LAST_IDX) begin
              state <= S_LISTEN;
            end else begin
              byteNo <= byteNo + 1'b1;
              state  <= S_STOP;
            end
          end
        end
        S_STOP: if (sts.halfDone) state <= S_GAP;
        S_GAP: begin
          if (sts.startFound)
            state <= S_RX;
          else if (sts.waitExpired)
            state <= S_LISTEN;
        end
        default: state <= S_LISTEN;
      endcase
    end
  end

  // R7: mode moves only on a decoded command
  a_r7_mode_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |-> cmdValid);

  // R7: read-ID leaves a non-default mode untouched
  a_r7_id_from_read: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == K_RDID && $past(mode) != MODE_READ) |-> mode == $past(mode));

  // R10: a blocked listener never arms
  a_r10_blocked_listen: assert property (@(posedge clk) disable iff (!rstN)
    (sts.blocked && state == S_LISTEN) |=> state == S_LISTEN);

  // R8: inter-byte hunting only follows the stop half-bit
  a_r8_gap_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP && $past(state) != S_GAP) |-> $past(state) == S_STOP);

  // R5: bytes are only published out of reception
  a_r5_byte_from_rx: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(state) == S_RX);

endmodule

// File: rtl/envCmdRx.sv
module envCmdRx
  import envrx_pkg::*;
#(
  parameter int BIT_CLKS       = 64,
  parameter int SYNC_HIGHS     = 4,
  parameter int SYNC_WAIT_BITS = 8,
  parameter int GAP_WAIT_BITS  = 2,
  parameter int BLOCK_BITS     = 128,
  parameter int WRITE_BYTES    = 4,
  localparam int IW            = $clog2(WRITE_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitStrobe,
  input  logic          fieldHigh,
  output logic          cmdValid,
  output logic [2:0]    cmdKind,
  output logic          byteValid,
  output logic [7:0]    byteData,
  output logic [IW-1:0] byteIdx,
  output logic [1:0]    mode,
  output logic          loadOn,
  output logic          rxBusy
);

  rxCtl_t   ctl;
  rxSts_t   sts;
  cmdKind_t kindQ;
  rdMode_t  modeQ;

  envRxDatapath #(
    .BIT_CLKS(BIT_CLKS), .SYNC_HIGHS(SYNC_HIGHS), .SYNC_WAIT_BITS(SYNC_WAIT_BITS),
    .GAP_WAIT_BITS(GAP_WAIT_BITS), .BLOCK_BITS(BLOCK_BITS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .fieldHigh(fieldHigh),
    .ctl(ctl), .sts(sts)
  );

  envRxControl #(.WRITE_BYTES(WRITE_BYTES), .IW(IW)) i_control (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .fieldHigh(fieldHigh),
    .sts(sts), .ctl(ctl), .cmdValid(cmdValid), .cmdKind(kindQ),
    .byteValid(byteValid), .byteData(byteData), .byteIdx(byteIdx),
    .mode(modeQ), .loadOn(loadOn), .rxBusy(rxBusy)
  );

  assign cmdKind = kindQ;
  assign mode    = modeQ;

endmodule

// File: tb/test_envCmdRx.sv
module test_envCmdRx;

  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       fieldHigh = 1'b1;
  logic       cmdValid, byteValid, loadOn, rxBusy;
  logic [2:0] cmdKind;
  logic [7:0] byteData;
  logic [1:0] byteIdx;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit         isCmd;
    logic [2:0] kind;
    logic [1:0] idx;
    logic [7:0] data;
  } exp_t;
  exp_t expQ[$];

  envCmdRx i_envCmdRx (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .fieldHigh(fieldHigh),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .byteValid(byteValid),
    .byteData(byteData), .byteIdx(byteIdx), .mode(mode),
    .loadOn(loadOn), .rxBusy(rxBusy)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // command classes taken from R6
  function automatic logic [2:0] kindOf(input logic [7:0] b);
    if (b == 8'hA0) return 3'd1;
    if (b == 8'hA5) return 3'd2;
    if (b == 8'hF0) return 3'd3;
    if (b[7:4] == 4'hC) return 3'd4;
    if (b == 8'hD3) return 3'd5;
    return 3'd6;
  endfunction

  task automatic waitBits(input int n);
    repeat (n * BIT) @(negedge clk);
  endtask

  task automatic sendBit(input bit v);
    fieldHigh = v;
    waitBits(1);
  endtask

  task automatic expectFrame(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.isCmd = (i == 0);
      e.data  = w[31-8*i -: 8];
      e.kind  = kindOf(w[31:24]);
      e.idx   = 2'(i);
      expQ.push_back(e);
    end
  endtask

  // envelope, then n framed bytes taken MSB-first from w
  task automatic sendFrame(input logic [31:0] w, input int n, input bit live);
    fieldHigh = 1'b1; waitBits(6);
    fieldHigh = 1'b0; waitBits(3);
    fieldHigh = 1'b1; waitBits(2);
    if (live) begin
      chk("R2 rxBusy in phase three", rxBusy, 1);
      chk("R2 load held on", loadOn, 1);
    end
    waitBits(1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = w[31-8*i -: 8];
      sendBit(1'b0);
      for (int j = 7; j >= 0; j--) sendBit(b[j]);
      sendBit(1'b1);
    end
    waitBits(3);
    chk("R6 scoreboard drained", expQ.size(), 0);
  endtask

  // bit strobe divider
  initial begin
    int bc = 0;
    forever begin
      @(negedge clk);
      bc = (bc == BIT - 1) ? 0 : bc + 1;
      bitStrobe = (bc == BIT - 1);
    end
  end

  // monitor: scoreboard compare and load-run measurement
  initial begin
    int offRun = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (byteValid || cmdValid) begin
          if (expQ.size() == 0) begin
            chk("R10 unexpected byte output", {byteValid, cmdValid}, 0);
          end else begin
            exp_t e;
            e = expQ.pop_front();
            chk("R5 byte value", byteData, e.data);
            chk("R8 byte index", byteIdx, e.idx);
            chk("R6 cmdValid with first byte", cmdValid, e.isCmd);
            if (e.isCmd) chk("R6 command class", cmdKind, e.kind);
          end
        end
        if (rxBusy && !loadOn) offRun++;
        else if (rxBusy && loadOn) begin
          if (offRun > 0) chk("R4 load off for half a bit", offRun, BIT / 2);
          offRun = 0;
        end else offRun = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 loadOn", loadOn, 0);
    chk("R1 rxBusy", rxBusy, 0);
    chk("R1 cmdValid", cmdValid, 0);
    chk("R1 byteValid", byteValid, 0);

    // R10: envelope inside the post-reset window is ignored
    sendFrame(32'hA5000000, 1, 1'b0);
    chk("R10 mode after blocked frame", mode, 0);
    waitBits(110);

    // R6 R7: read ID from default mode
    expectFrame(32'hA5000000, 1);
    sendFrame(32'hA5000000, 1, 1'b1);
    chk("R7 read ID sets mode 1", mode, 1);

    // R7: read configuration refused outside default mode
    expectFrame(32'hF0000000, 1);
    sendFrame(32'hF0000000, 1, 1'b1);
    chk("R7 read cfg ignored in ID mode", mode, 1);

    // R6: unknown code
    expectFrame(32'h3C000000, 1);
    sendFrame(32'h3C000000, 1, 1'b1);
    chk("R6 unknown leaves mode", mode, 1);

    // R8: word write frame and configuration write frame
    expectFrame(32'hC5D22D20, 4);
    sendFrame(32'hC5D22D20, 4, 1'b1);
    expectFrame(32'hD302552F, 4);
    sendFrame(32'hD302552F, 4, 1'b1);
    chk("R8 writes leave mode", mode, 1);

    // R9: write byte with no follower times out, no block
    expectFrame(32'hC7000000, 1);
    sendFrame(32'hC7000000, 1, 1'b1);
    chk("R9 receiver released", rxBusy, 0);
    expectFrame(32'hA0000000, 1);
    sendFrame(32'hA0000000, 1, 1'b1);
    chk("R7 reset returns mode 0", mode, 0);

    // R10: window after a reset command
    sendFrame(32'hF0000000, 1, 1'b0);
    chk("R10 mode after blocked cfg read", mode, 0);
    waitBits(130);
    expectFrame(32'hF0000000, 1);
    sendFrame(32'hF0000000, 1, 1'b1);
    chk("R7 read cfg sets mode 2", mode, 2);

    // R3: no high after the low sample -> envelope watchdog
    fieldHigh = 1'b1; waitBits(6);
    fieldHigh = 1'b0; waitBits(4);
    chk("R3 hunting holds load", {rxBusy, loadOn}, 2'b11);
    waitBits(7);
    chk("R3 watchdog released load", rxBusy, 0);
    fieldHigh = 1'b1;
    // R10: window after the watchdog timeout blocks a reset command
    sendFrame(32'hA0000000, 1, 1'b0);
    chk("R10 reset ignored in window", mode, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule